// File: doc/BRIEF.md
# Flow-Controlled Fixed-Latency Memory Reader

This block places a synchronous table memory with a fixed read latency behind a request/response handshake. A client offers a read address with `reqValid`, and the address is taken on a clock edge where `reqReady` is high. The word comes back a fixed number of cycles later. It is held in a small response queue. The client sees the oldest queued word on `respData` while `respValid` is high, and removes it by raising `respDeq`. A separate write port loads the table.

A credit counter tracks every accepted read until the client dequeues its answer. New requests are refused once the credits match the response queue depth. Every word that leaves the memory pipeline therefore has a queue slot waiting for it, even though the memory pipeline itself cannot be stalled. A dequeue in the same cycle frees its credit at once, so a client that drains every cycle can issue one read per cycle without gaps. A valid-bit shift line runs beside the memory pipeline and marks which output cycles carry a real answer.

Top module: `lat_mem_wrap`

## Requirements
- R1: After reset, `reqReady` is 1 and `respValid` is 0.
- R2: A read accepted on a clock edge shows up on `respValid`/`respData` exactly LAT edges later (default 3), carrying the word stored at its address.
- R3: Responses leave in the order their requests were accepted, including back-to-back requests on consecutive cycles.
- R4: When DEPTH reads (default 4) are accepted and not yet dequeued, and no dequeue is offered, `reqReady` is 0. A request presented while `reqReady` is 0 is not taken and produces no response.
- R5: Raising `respDeq` while `respValid` is 0 has no effect. In particular it frees no credit, so DEPTH new reads are still accepted afterwards, and no more.
- R6: A dequeue of a valid response frees its credit in the same cycle. A request offered then is accepted even when all credits are in use, and the credit count stays unchanged. A client that dequeues every response as soon as it is visible can sustain one accepted read per cycle.
- R7: While `respValid` is 1 and `respDeq` is 0, `respData` and `respValid` hold their values into the next cycle.
- R8: A word written through the write port is returned to reads accepted in later cycles. A read accepted in the same cycle as a write to the same address returns the previous word.
- R9: With dequeue stalled, all DEPTH accepted responses are kept and are later delivered intact and in order; the response queue never holds more than DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Client offers a read |
| reqReady | output | 1 | Read is accepted on this edge if offered |
| reqAddr | input | ADDR_W | Read address |
| respValid | output | 1 | Oldest response is present |
| respData | output | DATA_W | Oldest response word |
| respDeq | input | 1 | Remove the oldest response |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | ADDR_W | Table write address |
| wrData | input | DATA_W | Table write data |

## Verification
The hardest state to reach from the ports is the one where every credit is in use, the memory pipeline still has answers in flight, and a dequeue and a new request arrive in the same cycle. Only the same-cycle credit release lets the request through there. The streaming scenario reaches this state by raising `respDeq` first in each cycle and then deciding whether to offer a read from the resulting `reqReady`. The bench counts any stall as a failure. A second scenario stops dequeuing altogether and keeps requests pending past the credit limit. It then drains the queue to show that the refused requests left no trace and that the held words are intact.

// File: rtl/memwrap_pkg.sv
package memwrap_pkg;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic reqFire;   // launch a table read this edge
    logic deqFire;   // pop oldest queued response
    logic enqResp;   // memory pipe output carries a real response
  } wrapStrobe_t;

endpackage

// File: rtl/memwrap_ram.sv
module memwrap_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] store [WORDS];
  logic [DATA_W-1:0] stage [LAT];

  // read sees the word present before a same-edge write
  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    if (rdEn) stage[0] <= store[rdAddr];
    for (int s = 1; s < LAT; s++) stage[s] <= stage[s-1];
  end

  assign rdData = stage[LAT-1];
endmodule

// File: rtl/memwrap_respq.sv
module memwrap_respq #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enq,
  input  logic [DATA_W-1:0]          enqData,
  input  logic                       deq,
  output logic                       notEmpty,
  output logic [DATA_W-1:0]          headData,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (enq) slots[wrPtr] <= enqData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (enq) wrPtr <= bump(wrPtr);
      if (deq) rdPtr <= bump(rdPtr);
      case ({enq, deq})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign notEmpty = (cnt != '0);
  assign headData = slots[rdPtr];
  assign level    = cnt;
endmodule

// File: rtl/memwrap_dp.sv
module memwrap_dp
  import memwrap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LAT    = 3,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  wrapStrobe_t                strobe,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic                       queueNotEmpty,
  output logic [DATA_W-1:0]          respData,
  output logic [$clog2(DEPTH+1)-1:0] queueLevel
);
  logic [DATA_W-1:0] pipeOut;

  memwrap_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) u_ram (
    .clk    (clk),
    .rdEn   (strobe.reqFire),
    .rdAddr (reqAddr),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdData (pipeOut)
  );

  memwrap_respq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
    .clk      (clk),
    .rstN     (rstN),
    .enq      (strobe.enqResp),
    .enqData  (pipeOut),
    .deq      (strobe.deqFire),
    .notEmpty (queueNotEmpty),
    .headData (respData),
    .level    (queueLevel)
  );
endmodule

// File: rtl/memwrap_ctrl.sv
module memwrap_ctrl
  import memwrap_pkg::*;
#(
  parameter int LAT   = 3,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       respDeq,
  input  logic                       queueNotEmpty,
  output logic                       reqReady,
  output logic                       respValid,
  output wrapStrobe_t                strobe,
  output logic [$clog2(DEPTH+1)-1:0] credit
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [LAT-1:0]   validLine;
  logic [CNT_W-1:0] used;
  logic             deqFire, reqFire;

  assign deqFire   = respDeq && queueNotEmpty;
  // a dequeue this cycle hands its credit straight to a new request
  assign reqReady  = (used < CAP) || deqFire;
  assign reqFire   = reqValid && reqReady;
  assign respValid = queueNotEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validLine <= '0;
      used      <= '0;
    end else begin
      validLine <= (validLine << 1) | LAT'(reqFire);
      case ({reqFire, deqFire})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

  assign strobe.reqFire = reqFire;
  assign strobe.deqFire = deqFire;
  assign strobe.enqResp = validLine[LAT-1];
  assign credit         = used;
endmodule

// File: rtl/lat_mem_wrap.sv
module lat_mem_wrap
  import memwrap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LAT    = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  input  logic              respDeq,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  wrapStrobe_t      strobe;
  logic             queueNotEmpty;
  logic [CNT_W-1:0] credit;
  logic [CNT_W-1:0] queueLevel;

  memwrap_ctrl #(.LAT(LAT), .DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .respDeq       (respDeq),
    .queueNotEmpty (queueNotEmpty),
    .reqReady      (reqReady),
    .respValid     (respValid),
    .strobe        (strobe),
    .credit        (credit)
  );

  memwrap_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT), .DEPTH(DEPTH)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqAddr       (reqAddr),
    .wrEn          (wrEn),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .queueNotEmpty (queueNotEmpty),
    .respData      (respData),
    .queueLevel    (queueLevel)
  );
endmodule

// File: rtl/memwrap_chk.sv
module memwrap_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              respValid,
  input logic [DATA_W-1:0] respData,
  input logic              respDeq,
  input logic [CNT_W-1:0]  credit,
  input logic [CNT_W-1:0]  queueLevel
);
  // outstanding reads as seen purely from the ports
  logic [7:0] portCnt;
  logic       accept, takeOut;

  assign accept  = reqValid && reqReady;
  assign takeOut = respDeq && respValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portCnt <= '0;
    else portCnt <= portCnt + {7'd0, accept} - {7'd0, takeOut};
  end

  // R4 / R6: ready follows port-level credit with same-cycle release
  assert_ready_rule_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqReady == ((portCnt < 8'(DEPTH)) || takeOut));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (queueLevel <= CNT_W'(DEPTH)) && (queueLevel <= credit));

  assert_peek_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respDeq) |=> (respValid && $stable(respData)));

  assert_deq_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (respDeq && !respValid && !accept) |=> $stable(credit));

  assert_credit_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && takeOut) |=> $stable(credit));
endmodule

bind lat_mem_wrap memwrap_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .respValid  (respValid),
  .respData   (respData),
  .respDeq    (respDeq),
  .credit     (credit),
  .queueLevel (queueLevel)
);

// File: tb/sim_lat_mem_wrap.sv
`timescale 1ns/1ps
module sim_lat_mem_wrap;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int LAT    = 3;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              respValid;
  logic [DATA_W-1:0] respData;
  logic              respDeq = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] refMem [1 << ADDR_W];
  logic [DATA_W-1:0] expQ [256];
  int head = 0;
  int tail = 0;

  always #2 clk = ~clk;

  lat_mem_wrap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .respValid(respValid), .respData(respData),
    .respDeq(respDeq), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] tblVal(input int i);
    return DATA_W'(i * 97) ^ 16'h5A3C;
  endfunction

  // drain queued responses, comparing each with the expected order
  task automatic drain(input string tag, output int got);
    got = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (respValid) begin
        check(respData == expQ[head], tag, respData, expQ[head]);
        head++;
        got++;
        respDeq = 1'b1;
      end else begin
        respDeq = 1'b0;
      end
    end
    respDeq = 1'b0;
  endtask

  // offer requests without dequeuing; returns how many were accepted
  task automatic fill(input int tries, input int base, output int fires);
    fires = 0;
    for (int i = 0; i < tries; i++) begin
      @(negedge clk);
      reqValid = 1'b1;
      reqAddr  = ADDR_W'(base + i);
      if (reqReady) begin
        expQ[tail] = refMem[base + i];
        tail++;
        fires++;
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reqReady after reset", reqReady, 1);
    check(respValid == 1'b0, "R1 respValid after reset", respValid, 0);
  endtask

  task automatic load_table();
    for (int i = 0; i < (1 << ADDR_W); i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = ADDR_W'(i); wrData = tblVal(i);
      refMem[i] = tblVal(i);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic test_latency(input int addr);
    int lat;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = ADDR_W'(addr);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!respValid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == LAT, "R2 response latency", lat, LAT);
    check(respData == refMem[addr], "R2 response data", respData, refMem[addr]);
    respDeq = 1'b1;
    @(negedge clk);
    respDeq = 1'b0;
    check(respValid == 1'b0, "R2 queue empty after deq", respValid, 0);
  endtask

  task automatic test_stream();
    int sent = 0;
    int stalls = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (respValid) begin
        check(respData == expQ[head], "R3 in-order stream data", respData, expQ[head]);
        head++;
        respDeq = 1'b1;
      end else begin
        respDeq = 1'b0;
      end
      #1;
      if (sent < 40) begin
        if (reqReady) begin
          reqValid = 1'b1;
          reqAddr  = ADDR_W'((sent * 53 + 7) % 256);
          expQ[tail] = refMem[(sent * 53 + 7) % 256];
          tail++;
          sent++;
        end else begin
          reqValid = 1'b0;
          stalls++;
        end
      end else begin
        reqValid = 1'b0;
      end
      if (sent == 40 && head == tail) break;
    end
    @(negedge clk);
    respDeq = 1'b0; reqValid = 1'b0;
    check(stalls == 0, "R6 full-rate stream stalls", stalls, 0);
    check(head == tail, "R3 all stream responses seen", head, tail);
  endtask

  task automatic test_backpressure();
    int fires, got;
    logic [DATA_W-1:0] held;
    fill(DEPTH + 3, 100, fires);
    check(fires == DEPTH, "R4 accepted reads at credit limit", fires, DEPTH);
    repeat (LAT + 1) @(negedge clk);
    check(reqReady == 1'b0, "R4 reqReady low when full", reqReady, 0);
    check(respValid == 1'b1, "R9 responses held", respValid, 1);
    held = respData;
    @(negedge clk);
    check(respData == held && respValid, "R7 head stable without deq", respData, held);
    drain("R9 held responses intact", got);
    check(got == DEPTH, "R4 refused requests produced nothing", got, DEPTH);
    check(respValid == 1'b0, "R4 queue empty after drain", respValid, 0);
  endtask

  task automatic test_deq_empty();
    int fires, got;
    @(negedge clk);
    respDeq = 1'b1;
    repeat (3) @(negedge clk);
    respDeq = 1'b0;
    check(respValid == 1'b0, "R5 still empty", respValid, 0);
    fill(DEPTH + 2, 180, fires);
    check(fires == DEPTH, "R5 empty deq freed no credit", fires, DEPTH);
    drain("R5 drain data", got);
    check(got == DEPTH, "R5 drain count", got, DEPTH);
  endtask

  task automatic test_write_collision();
    int got;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'd9; wrData = 16'hBEEF;
    reqValid = 1'b1; reqAddr = 8'd9;
    expQ[tail] = refMem[9]; tail++;
    @(negedge clk);
    wrEn = 1'b0;
    refMem[9] = 16'hBEEF;
    reqValid = 1'b1; reqAddr = 8'd9;
    expQ[tail] = 16'hBEEF; tail++;
    @(negedge clk);
    reqValid = 1'b0;
    drain("R8 write then read ordering", got);
    check(got == 2, "R8 response count", got, 2);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    load_table();
    test_latency(5);
    test_latency(200);
    test_stream();
    test_backpressure();
    test_deq_empty();
    test_write_collision();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule